// File: doc/BRIEF.md
# Sigma-Delta Bitstream Channel Receiver

This block takes the one-bit output of an external sigma-delta modulator on a single input channel. It turns that output into a stream of recovered bits for a decimation filter that sits after it. Each recovered bit is reported as a signed symbol (+1 or -1) with a one-cycle valid strobe in the system clock domain. The bit timing comes from one of two places. In the clocked serial modes a bit clock is used, taken either from an external pin or from an internally generated clock, and data is sampled on the chosen clock edge. In the Manchester modes the timing is recovered from the data line itself, using a programmable nominal half-bit period.

The data pin, the external clock pin and the selected internal clock level all pass through a two-flop synchroniser before edges are detected, so the system clock must run at four or more times the bit rate. When an internal clock source is chosen and the channel is enabled, the block drives that clock on its clock output and acts as bus master. An alternate-input select makes the channel read the neighbouring channel's data pin instead of its own.

Top module: `sdrx_chan_rx`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, `bit_vld`, `bclk_out` and `bit_val` are all 0.
- R2: Mode 0 (`mode_sel`=0) captures data on rising bit-clock edges. Take edges k-1 and k, where the bit-clock level is sampled low at k-1 and high at k. Then `bit_vld` is high for exactly the one cycle after edge k+2, carrying the data level sampled at edge k.
- R3: Mode 1 (`mode_sel`=1) has the same timing as R2, but on a falling bit-clock edge (high at k-1, low at k).
- R4: A recovered 1 is output as `bit_val`=2'b01 (+1) and a recovered 0 as 2'b11 (-1). `bit_val` holds its value between strobes.
- R5: Mode 2 (`mode_sel`=2) is Manchester decoding. Let H be `half_period` (H >= 2). A data transition is accepted when at least H + floor(H/2) cycles have passed since the last accepted transition; earlier transitions are ignored. The first transition after enabling is always accepted. A rising accepted transition decodes 0, a falling one decodes 1, and the strobe comes two cycles after the transition is sampled.
- R6: Mode 3 (`mode_sel`=3) is Manchester with the opposite polarity: a rising accepted transition decodes 1 and a falling one decodes 0. Its acceptance rules are the same as R5.
- R7: `src_sel` picks the bit clock. 0 is `ext_bclk`. 1 is `int_bclk` registered once. 2 is a half-rate clock, inverted. 3 is the same half-rate clock uninverted. The half-rate clock starts at 0 after reset and toggles on every rising edge of the registered `int_bclk`.
- R8: `bclk_out` is the internal bit-clock level selected by `src_sel`, delayed by one register stage, while `chan_en`=1 and `src_sel`!=0. It is 0 otherwise.
- R9: With `alt_sel`=1 data is taken from `data_alt`, and `data_own` has no effect. With `alt_sel`=0 data is taken from `data_own`.
- R10: With `chan_en`=0 no `bit_vld` strobe is produced. The Manchester timing restarts, so the first transition after re-enabling is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel capture enable |
| mode_sel | input | 2 | Line mode: 0 clocked rising, 1 clocked falling, 2/3 Manchester |
| src_sel | input | 2 | Bit-clock source: 0 external, 1 internal, 2 half-rate inverted, 3 half-rate |
| alt_sel | input | 1 | Take data from the neighbouring channel's pin |
| data_own | input | 1 | This channel's modulator data pin (asynchronous) |
| data_alt | input | 1 | Neighbouring channel's data pin (asynchronous) |
| ext_bclk | input | 1 | External bit clock pin (asynchronous) |
| int_bclk | input | 1 | Internally generated clock, synchronous to clk |
| half_period | input | HP_W | Manchester nominal half-bit period in system cycles |
| bclk_out | output | 1 | Bit clock driven to the modulator when master |
| bit_vld | output | 1 | One-cycle strobe: a recovered bit is present |
| bit_val | output | 2 | Recovered bit as a signed symbol (+1 / -1) |

## Verification
Some properties are checked by assertions on every cycle. The edge detector never reports the same edge direction on two consecutive cycles. The Manchester acceptance window keeps strobes at least two cycles apart. The half-rate divider changes only on a rising internal clock. Disabled channels and external-clock operation stay silent on their outputs, and every strobe carries a legal symbol. Other behaviours can only be shown by the bench's scenarios, against its cycle model and decoded-bit queues. These are the exact strobe latency, the data value captured, the polarity conventions of the two Manchester modes, the precise boundary of the acceptance window, the strobe rate for each clock source, and the alternate-pin selection.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;

  typedef enum logic [1:0] {
    RX_CLK_RISE = 2'd0,
    RX_CLK_FALL = 2'd1,
    RX_MAN_R0   = 2'd2,
    RX_MAN_R1   = 2'd3
  } rx_mode_t;

  typedef enum logic [1:0] {
    SRC_EXT      = 2'd0,
    SRC_INT      = 2'd1,
    SRC_HALF_INV = 2'd2,
    SRC_HALF     = 2'd3
  } clk_src_t;

  localparam logic signed [1:0] SYM_POS = 2'sb01;
  localparam logic signed [1:0] SYM_NEG = 2'sb11;

  function automatic logic signed [1:0] bit_to_sym(input logic b);
    return b ? SYM_POS : SYM_NEG;
  endfunction

endpackage

// File: rtl/sdrx_sync.sv
module sdrx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdrx_clkgen.sv
module sdrx_clkgen
  import sdrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       int_bclk,
  input  logic [1:0] src_sel,
  output logic       int_lvl
);
  logic int_q;
  logic half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      int_q <= int_bclk;
      if (int_bclk && !int_q) half_q <= ~half_q;
    end
  end

  always_comb begin
    case (clk_src_t'(src_sel))
      SRC_HALF_INV: int_lvl = ~half_q;
      SRC_HALF:     int_lvl = half_q;
      default:      int_lvl = int_q;
    endcase
  end

  // R7
  half_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(half_q) |-> $rose(int_q));
endmodule

// File: rtl/sdrx_edge.sv
module sdrx_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic dat,
  input  logic fall_sel,
  output logic stb,
  output logic bit_o
);
  logic prev;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise  = lvl & ~prev;
  assign fall  = ~lvl & prev;
  assign stb   = fall_sel ? fall : rise;
  assign bit_o = dat;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/sdrx_manch.sv
module sdrx_manch #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            dat,
  input  logic            invert,
  input  logic [HP_W-1:0] half,
  output logic            stb,
  output logic            bit_o
);
  localparam int CNT_W = HP_W + 1;
  localparam logic [CNT_W-1:0] SAT = '1;

  logic             dprev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] thr;
  logic             trans;

  assign thr   = {1'b0, half} + {2'b00, half[HP_W-1:1]};
  assign trans = dat ^ dprev;
  assign stb   = active & trans & (cnt >= thr);
  assign bit_o = invert ? dat : dprev;

  always_ff @(posedge clk) begin
    if (rst) begin
      dprev <= 1'b0;
      cnt   <= SAT;
    end else begin
      dprev <= dat;
      if (!active)         cnt <= SAT;
      else if (stb)        cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (cnt != SAT) cnt <= cnt + 1'b1;
    end
  end

  // R5
  accept_gap_chk: assert property (@(posedge clk) disable iff (rst || half < 2)
    stb |=> !stb);
endmodule

// File: rtl/sdrx_chan_rx.sv
module sdrx_chan_rx
  import sdrx_pkg::*;
#(
  parameter int HP_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chan_en,
  input  logic [1:0]         mode_sel,
  input  logic [1:0]         src_sel,
  input  logic               alt_sel,
  input  logic               data_own,
  input  logic               data_alt,
  input  logic               ext_bclk,
  input  logic               int_bclk,
  input  logic [HP_W-1:0]    half_period,
  output logic               bclk_out,
  output logic               bit_vld,
  output logic signed [1:0]  bit_val
);
  logic       int_lvl;
  logic       clk_raw;
  logic       data_raw;
  logic [1:0] sync_q;
  logic       e_stb, e_bit;
  logic       m_stb, m_bit;
  logic       evt, evt_bit;
  logic       is_ext;

  assign is_ext = (clk_src_t'(src_sel) == SRC_EXT);

  sdrx_clkgen u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .int_bclk (int_bclk),
    .src_sel  (src_sel),
    .int_lvl  (int_lvl)
  );

  assign clk_raw  = is_ext ? ext_bclk : int_lvl;
  assign data_raw = alt_sel ? data_alt : data_own;

  sdrx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({clk_raw, data_raw}),
    .q   (sync_q)
  );

  sdrx_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .lvl      (sync_q[1]),
    .dat      (sync_q[0]),
    .fall_sel (rx_mode_t'(mode_sel) == RX_CLK_FALL),
    .stb      (e_stb),
    .bit_o    (e_bit)
  );

  sdrx_manch #(.HP_W(HP_W)) u_manch (
    .clk    (clk),
    .rst    (rst),
    .active (chan_en & mode_sel[1]),
    .dat    (sync_q[0]),
    .invert (mode_sel[0]),
    .half   (half_period),
    .stb    (m_stb),
    .bit_o  (m_bit)
  );

  assign evt     = mode_sel[1] ? m_stb : e_stb;
  assign evt_bit = mode_sel[1] ? m_bit : e_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_vld  <= 1'b0;
      bit_val  <= 2'sb00;
      bclk_out <= 1'b0;
    end else begin
      bit_vld  <= chan_en & evt;
      if (chan_en & evt) bit_val <= bit_to_sym(evt_bit);
      bclk_out <= (chan_en && !is_ext) ? int_lvl : 1'b0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bit_vld && !bclk_out && bit_val == 2'sb00));
  // R10
  disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !bit_vld);
  // R8
  ext_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (is_ext || !chan_en) |=> !bclk_out);
  // R4
  symbol_legal_chk: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> (bit_val == SYM_POS || bit_val == SYM_NEG));
endmodule

// File: tb/sdrx_chan_rx_test.sv
module sdrx_chan_rx_test;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              chan_en = 1'b0;
  logic [1:0]        mode_sel = 2'd0;
  logic [1:0]        src_sel = 2'd0;
  logic              alt_sel = 1'b0;
  logic              data_own = 1'b0;
  logic              data_alt = 1'b0;
  logic              ext_bclk = 1'b0;
  logic              int_bclk = 1'b0;
  logic [7:0]        half_period = 8'd6;
  logic              bclk_out;
  logic              bit_vld;
  logic signed [1:0] bit_val;

  sdrx_chan_rx #(.HP_W(8), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .mode_sel(mode_sel),
    .src_sel(src_sel), .alt_sel(alt_sel), .data_own(data_own),
    .data_alt(data_alt), .ext_bclk(ext_bclk), .int_bclk(int_bclk),
    .half_period(half_period), .bclk_out(bclk_out), .bit_vld(bit_vld),
    .bit_val(bit_val)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int vld_cnt = 0;
  string cur_req = "R1";
  bit dec_q[$];
  bit sent_q[$];
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  localparam int SAT = 511;
  bit m_started = 0;
  bit hE1, hE2, hE3, hD1, hD2, hD3;
  bit m_intq, m_half;
  int m_since = SAT;
  bit exp_vld, exp_bclk;
  int exp_val = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic bit next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  always @(posedge clk) begin
    bit e, d, evt, val, trans;
    int thr;
    m_started = 1;
    if (rst) begin
      {hE1, hE2, hE3, hD1, hD2, hD3} = '0;
      m_intq = 0; m_half = 0; m_since = SAT;
      exp_vld = 0; exp_bclk = 0; exp_val = 0;
    end else begin
      case (src_sel)
        2'd0: e = ext_bclk;
        2'd1: e = m_intq;
        2'd2: e = ~m_half;
        default: e = m_half;
      endcase
      d = alt_sel ? data_alt : data_own;
      evt = 0; val = 0;
      if (!mode_sel[1]) begin
        evt = (mode_sel == 2'd0) ? (hE2 && !hE3) : (!hE2 && hE3);
        val = hD2;
      end
      thr = int'(half_period) + int'(half_period) / 2;
      if (chan_en && mode_sel[1]) begin
        trans = (hD2 != hD3);
        evt = trans && (m_since >= thr);
        m_since = evt ? 1 : ((m_since + 1 > SAT) ? SAT : m_since + 1);
        val = (mode_sel == 2'd2) ? hD3 : hD2;
      end else begin
        m_since = SAT;
        if (mode_sel[1]) evt = 0;
      end
      exp_vld = chan_en && evt;
      if (exp_vld) exp_val = val ? 1 : -1;
      exp_bclk = (chan_en && src_sel != 2'd0) ? e : 1'b0;
      if (int_bclk && !m_intq) m_half = ~m_half;
      m_intq = int_bclk;
      hE3 = hE2; hE2 = hE1; hE1 = e;
      hD3 = hD2; hD2 = hD1; hD1 = d;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
    if (m_started) begin
      chk(bit_vld == exp_vld, cur_req, int'(bit_vld), int'(exp_vld));
      chk(bclk_out == exp_bclk, "R8", int'(bclk_out), int'(exp_bclk));
      if (exp_vld)
        chk(int'(bit_val) == exp_val, "R4", int'(bit_val), exp_val);
      if (bit_vld) begin
        vld_cnt++;
        dec_q.push_back(bit_val == 2'sb01);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_ext(input bit b, input bit first);
    if (alt_sel) begin data_alt = b; data_own = ~b; end
    else         begin data_own = b; data_alt = ~b; end
    ext_bclk = first;
    cyc(4);
    ext_bclk = ~first;
    cyc(4);
  endtask

  task automatic run_ext(input int nbits, input bit first, input string req);
    dec_q.delete(); sent_q.delete();
    for (int i = 0; i < nbits; i++) begin
      bit b;
      b = next_bit();
      sent_q.push_back(b);
      send_ext(b, first);
    end
    ext_bclk = 1'b0;
    cyc(6);
    chk(dec_q.size() == nbits, req, dec_q.size(), nbits);
    for (int i = 0; i < nbits && i < dec_q.size(); i++)
      chk(dec_q[i] == sent_q[i], req, int'(dec_q[i]), int'(sent_q[i]));
  endtask

  task automatic run_int(input int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      int_bclk = ((i % 4) < 2);
      data_own = next_bit();
      cyc(1);
    end
  endtask

  task automatic run_man(input bit inv, input int h, input bit jitter, input string req);
    int nb;
    nb = 16;
    chan_en = 1'b0;
    mode_sel = inv ? 2'd3 : 2'd2;
    half_period = 8'(h);
    sent_q.delete();
    for (int i = 0; i < nb; i++) sent_q.push_back(next_bit());
    data_own = sent_q[0] ^ inv;
    cyc(6);
    chan_en = 1'b1;
    cyc(2);
    dec_q.delete();
    for (int i = 0; i < nb; i++) begin
      int l1, l2;
      l1 = jitter ? h + ((i % 3) - 1) : h;
      l2 = jitter ? h + (((i + 1) % 3) - 1) : h;
      data_own = sent_q[i] ^ inv;
      cyc(l1);
      data_own = ~(sent_q[i] ^ inv);
      cyc(l2);
    end
    cyc(12);
    chk(dec_q.size() == nb, req, dec_q.size(), nb);
    for (int i = 0; i < nb && i < dec_q.size(); i++)
      chk(dec_q[i] == sent_q[i], req, int'(dec_q[i]), int'(sent_q[i]));
  endtask

  initial begin
    int c0;
    cyc(4);
    // R1: outputs quiet during reset
    chk(bit_vld == 1'b0 && bclk_out == 1'b0 && bit_val == 2'sb00, "R1",
        int'(bit_vld) + int'(bclk_out) + int'(bit_val), 0);
    rst = 1'b0;
    cyc(3);
    chk(bit_vld == 1'b0 && bclk_out == 1'b0, "R1", int'(bit_vld), 0);

    // R2: clocked rising capture, external clock
    cur_req = "R2";
    chan_en = 1'b1; mode_sel = 2'd0; src_sel = 2'd0;
    run_ext(12, 1'b0, "R2");

    // R3: clocked falling capture
    cur_req = "R3";
    mode_sel = 2'd1;
    run_ext(12, 1'b1, "R3");

    // R9: alternate data pin
    cur_req = "R9";
    mode_sel = 2'd0; alt_sel = 1'b1;
    run_ext(10, 1'b0, "R9");
    alt_sel = 1'b0;

    // R7: internal clock sources, strobe rate over a whole number of periods
    cur_req = "R7";
    for (int s = 1; s <= 3; s++) begin
      for (int m = 0; m <= 1; m++) begin
        src_sel = 2'(s); mode_sel = 2'(m);
        run_int(16);
        c0 = vld_cnt;
        run_int(64);
        chk(vld_cnt - c0 == ((s == 1) ? 16 : 8), "R7", vld_cnt - c0, (s == 1) ? 16 : 8);
      end
    end
    int_bclk = 1'b0;
    cyc(8);

    // R10: disabled channel produces nothing, no clock driven
    cur_req = "R10";
    chan_en = 1'b0; src_sel = 2'd0; mode_sel = 2'd0;
    c0 = vld_cnt;
    for (int i = 0; i < 6; i++) send_ext(next_bit(), 1'b0);
    ext_bclk = 1'b0;
    src_sel = 2'd1;
    run_int(32);
    int_bclk = 1'b0;
    cyc(6);
    chk(vld_cnt == c0, "R10", vld_cnt - c0, 0);
    src_sel = 2'd0;

    // R5: Manchester, rising = 0
    cur_req = "R5";
    run_man(1'b0, 6, 1'b0, "R5");

    // R5: acceptance boundary (H=6, window 9): toggle at 8 ignored, then at 17 accepted
    c0 = vld_cnt;
    data_own = ~data_own;
    cyc(8);
    data_own = ~data_own;
    cyc(9);
    data_own = ~data_own;
    cyc(6);
    chk(vld_cnt - c0 == 2, "R5", vld_cnt - c0, 2);

    // R6: Manchester, rising = 1, with half-period jitter
    cur_req = "R6";
    run_man(1'b1, 7, 1'b1, "R6");

    // R10: Manchester restarts after disable
    cur_req = "R10";
    run_man(1'b1, 6, 1'b0, "R10");

    chan_en = 1'b0;
    cyc(4);
    summary();
  end
endmodule